// File: doc/BRIEF.md
# Branch Target Lookup Table

This block is a small cache consulted at instruction fetch. It takes the address of the instruction being fetched and reports three things: whether that address is a known branch, the branch's 2-bit kind, and the target address it last resolved to. For the kinds that always redirect (call, plain jump) the target can be used at once. For a conditional kind the hit is passed on to a separate direction predictor. A return is flagged so that a return-address mechanism can supply its target. The table is set-associative and uses a truncated tag. Two branches whose addresses agree in the index and tag fields therefore share an entry. Such a false hit costs only a misprediction, so no logic corrects it.

Entries are never created at fetch. The execute stage writes them when a branch resolves, through a single write port that carries a strobe, an address, a kind and a target. If the written address already has a way in its set, that way is rewritten in place. Otherwise the way named by the set's rotating victim pointer is replaced, and that pointer then steps to the next way. The fetch result is registered and appears one cycle after the address is presented. A write in the same cycle is applied ahead of the lookup, so the fetch sees the new contents. All storage is in flip-flops.

Top module: `btb_array`

## Requirements
- R1: A synchronous reset clears every valid bit and every victim pointer. In the cycle after reset is sampled, `fetch_hit` is 0, and any address looked up after reset misses until it is written again.
- R2: With default parameters, the set index is address bits [8:2] and the stored tag is bits [16:9]. Bits [1:0] do not take part in the match, so addresses that differ only in bits [1:0] read the same entry. Addresses that differ in any tag bit do not match.
- R3: Address bits above the tag field (bits [31:17] by default) are not compared. Two addresses that differ only there hit the same entry.
- R4: When an address hits, `fetch_kind` and `fetch_target` carry the kind and target last written for it. They appear in the cycle after the address is presented.
- R5: The kind encoding is 00 conditional, 01 return, 10 call and 11 jump. On a hit, `fetch_jump` is 1 only for kinds 10 and 11 and `fetch_cond` is 1 only for kind 00. Both are 0 for kind 01 and on a miss.
- R6: A write whose address already matches a valid way in its set rewrites that way and leaves the set's victim pointer unchanged.
- R7: A write that misses in its set fills the way named by the set's victim pointer. The pointer starts at way 0 and advances by one modulo the way count, so the fifth allocation into a 4-way set evicts the first.
- R8: Each set has its own victim pointer. Allocations into one set do not move another set's pointer.
- R9: A lookup presented in the same cycle as a write to the same set returns the contents as they are after that write.
- R10: On a miss, `fetch_kind` and `fetch_target` are 0.
- R11: Write fields are ignored while `upd_valid` is 0. With no write and an unchanged fetch address, the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_addr | input | ADDR_W | Address of the instruction being fetched |
| fetch_hit | output | 1 | Registered: the address matched a valid entry |
| fetch_kind | output | 2 | Registered branch kind (00 cond, 01 return, 10 call, 11 jump) |
| fetch_target | output | TGT_W | Registered predicted target |
| fetch_jump | output | 1 | Hit with an always-redirecting kind (call or jump) |
| fetch_cond | output | 1 | Hit with a conditional kind, to be resolved by a direction predictor |
| upd_valid | input | 1 | Write strobe from the execute stage |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_kind | input | 2 | Kind of the resolved branch |
| upd_target | input | TGT_W | Resolved target |

## Verification
The hardest state to reach is one that shows which way a given write chose. Way numbers are not visible at the ports, so an eviction can only be inferred from which older branch stops hitting. The stimulus fills one set with addresses that share an index but carry different tags. It mixes in an in-place rewrite that must not move the pointer. It then allocates a fifth address and probes the address expected to be gone. If the pointer had advanced on the rewrite, a different entry would be lost one step earlier, and the probe of the surviving entry exposes it. A second set is filled afterwards to show that its pointer started from way 0. Same-cycle forwarding is driven by presenting the written address on the fetch side in the very cycle of the write.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [1:0] {
        BR_COND = 2'b00,
        BR_RET  = 2'b01,
        BR_CALL = 2'b10,
        BR_JUMP = 2'b11
    } br_kind_e;

    // kinds whose stored target redirects fetch without a direction guess
    function automatic logic kind_is_direct(br_kind_e k);
        return (k == BR_CALL) || (k == BR_JUMP);
    endfunction

endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 2,
    parameter int IDX_W  = 7,
    parameter int TAG_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    localparam int TAG_LO = OFS_W + IDX_W;
    localparam int TOP_LO = TAG_LO + TAG_W;

    assign idx = addr[OFS_W +: IDX_W];
    assign tag = addr[TAG_LO +: TAG_W];

    // bits below the index and above the tag never take part in a match
    logic unused_bits;
    assign unused_bits = ^{addr[ADDR_W-1:TOP_LO], addr[OFS_W-1:0]};

endmodule

// File: rtl/btb_way_match.sv
module btb_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]       vld,
    input  logic [WAYS*TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]      tag,
    output logic                  hit,
    output logic [WAY_W-1:0]      way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = vld[w] && (tags[w*TAG_W +: TAG_W] == tag);
    end

    assign hit = |match;

    // lowest matching way wins; writes keep tags unique within a set
    always_comb begin
        way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/btb_array.sv
module btb_array #(
    parameter int ADDR_W = 32,
    parameter int TGT_W  = 32,
    parameter int OFS_W  = 2,
    parameter int SETS   = 128,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_hit,
    output logic [1:0]        fetch_kind,
    output logic [TGT_W-1:0]  fetch_target,
    output logic              fetch_jump,
    output logic              fetch_cond,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [1:0]        upd_kind,
    input  logic [TGT_W-1:0]  upd_target
);
    import btb_pkg::*;

    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    typedef struct packed {
        logic               hit;
        br_kind_e           kind;
        logic [TGT_W-1:0]   target;
    } res_t;

    // storage
    logic [WAYS-1:0]  vld_q  [SETS];
    logic [WAYS-1:0]  vld_d  [SETS];
    logic [TAG_W-1:0] tag_q  [SETS][WAYS];
    logic [TAG_W-1:0] tag_d  [SETS][WAYS];
    logic [1:0]       kind_q [SETS][WAYS];
    logic [1:0]       kind_d [SETS][WAYS];
    logic [TGT_W-1:0] tgt_q  [SETS][WAYS];
    logic [TGT_W-1:0] tgt_d  [SETS][WAYS];
    logic [WAY_W-1:0] ptr_q  [SETS];
    logic [WAY_W-1:0] ptr_d  [SETS];
    res_t             res_q, res_d;

    // address fields
    logic [IDX_W-1:0] f_idx, u_idx;
    logic [TAG_W-1:0] f_tag, u_tag;

    btb_addr_split #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .TAG_W(TAG_W))
        u_fsplit (.addr(fetch_addr), .idx(f_idx), .tag(f_tag));

    btb_addr_split #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .TAG_W(TAG_W))
        u_usplit (.addr(upd_addr), .idx(u_idx), .tag(u_tag));

    // write side: find an existing way or take the victim
    logic [WAYS*TAG_W-1:0] u_tags;
    logic                  u_hit;
    logic [WAY_W-1:0]      u_hit_way, u_way;

    for (genvar w = 0; w < WAYS; w++) begin : g_utag
        assign u_tags[w*TAG_W +: TAG_W] = tag_q[u_idx][w];
    end

    btb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W))
        u_umatch (.vld(vld_q[u_idx]), .tags(u_tags), .tag(u_tag),
                  .hit(u_hit), .way(u_hit_way));

    assign u_way = u_hit ? u_hit_way : ptr_q[u_idx];

    // read side: view of the fetched set with this cycle's write folded in
    logic [WAYS-1:0]       f_vld;
    logic [WAYS*TAG_W-1:0] f_tags;
    logic [WAYS*2-1:0]     f_kinds;
    logic [WAYS*TGT_W-1:0] f_tgts;
    logic                  f_hit;
    logic [WAY_W-1:0]      f_way;

    for (genvar w = 0; w < WAYS; w++) begin : g_fview
        logic byp;
        assign byp = upd_valid && (u_idx == f_idx) && (u_way == WAY_W'(w));
        assign f_vld[w]                    = byp ? 1'b1       : vld_q[f_idx][w];
        assign f_tags[w*TAG_W +: TAG_W]    = byp ? u_tag      : tag_q[f_idx][w];
        assign f_kinds[w*2 +: 2]           = byp ? upd_kind   : kind_q[f_idx][w];
        assign f_tgts[w*TGT_W +: TGT_W]    = byp ? upd_target : tgt_q[f_idx][w];
    end

    btb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W))
        u_fmatch (.vld(f_vld), .tags(f_tags), .tag(f_tag),
                  .hit(f_hit), .way(f_way));

    // next-state computation
    always_comb begin
        vld_d  = vld_q;
        tag_d  = tag_q;
        kind_d = kind_q;
        tgt_d  = tgt_q;
        ptr_d  = ptr_q;

        if (upd_valid) begin
            vld_d[u_idx][u_way]  = 1'b1;
            tag_d[u_idx][u_way]  = u_tag;
            kind_d[u_idx][u_way] = upd_kind;
            tgt_d[u_idx][u_way]  = upd_target;
            if (!u_hit) begin
                ptr_d[u_idx] = (ptr_q[u_idx] == LAST_WAY) ? '0 : ptr_q[u_idx] + 1'b1;
            end
        end

        res_d.hit    = f_hit;
        res_d.kind   = BR_COND;
        res_d.target = '0;
        if (f_hit) begin
            res_d.kind   = br_kind_e'(f_kinds[int'(f_way)*2 +: 2]);
            res_d.target = f_tgts[int'(f_way)*TGT_W +: TGT_W];
        end
    end

    // registers with synchronous reset
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                ptr_q[s] <= '0;
            end
            res_q <= '0;
        end else begin
            vld_q <= vld_d;
            ptr_q <= ptr_d;
            res_q <= res_d;
        end
    end

    // payload needs no reset: it is only read behind a valid bit
    always_ff @(posedge clk) begin
        tag_q  <= tag_d;
        kind_q <= kind_d;
        tgt_q  <= tgt_d;
    end

    assign fetch_hit    = res_q.hit;
    assign fetch_kind   = res_q.kind;
    assign fetch_target = res_q.target;
    assign fetch_jump   = res_q.hit && kind_is_direct(res_q.kind);
    assign fetch_cond   = res_q.hit && (res_q.kind == BR_COND);

endmodule

// File: rtl/btb_array_chk.sv
module btb_array_chk #(
    parameter int ADDR_W = 32,
    parameter int TGT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_hit,
    input logic [1:0]        fetch_kind,
    input logic [TGT_W-1:0]  fetch_target,
    input logic              fetch_jump,
    input logic              fetch_cond,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] upd_addr,
    input logic [1:0]        upd_kind,
    input logic [TGT_W-1:0]  upd_target
);

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !fetch_hit);

    // R5
    jump_kind_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_jump |-> (fetch_hit && fetch_kind[1]));

    // R5
    cond_kind_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_cond |-> (fetch_hit && fetch_kind == 2'b00));

    // R10
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_hit |-> (fetch_kind == 2'b00 && fetch_target == '0));

    // R9
    same_cycle_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && fetch_addr == upd_addr) |=>
        (fetch_hit && fetch_kind == $past(upd_kind) && fetch_target == $past(upd_target)));

    // R11
    quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!upd_valid && fetch_addr == $past(fetch_addr)) |=>
        ($stable(fetch_hit) && $stable(fetch_target) && $stable(fetch_kind)));

endmodule

bind btb_array btb_array_chk #(.ADDR_W(ADDR_W), .TGT_W(TGT_W)) u_chk (
    .clk(clk), .rst(rst), .fetch_addr(fetch_addr),
    .fetch_hit(fetch_hit), .fetch_kind(fetch_kind), .fetch_target(fetch_target),
    .fetch_jump(fetch_jump), .fetch_cond(fetch_cond),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_kind(upd_kind),
    .upd_target(upd_target)
);

// File: tb/sim_btb_array.sv
module sim_btb_array;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int NV         = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_addr = '0;
    logic        fetch_hit, fetch_jump, fetch_cond;
    logic [1:0]  fetch_kind;
    logic [31:0] fetch_target;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_addr = '0;
    logic [1:0]  upd_kind = '0;
    logic [31:0] upd_target = '0;

    int nchecks = 0;
    int nerr    = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    btb_array u0 (
        .clk(clk), .rst(rst), .fetch_addr(fetch_addr),
        .fetch_hit(fetch_hit), .fetch_kind(fetch_kind), .fetch_target(fetch_target),
        .fetch_jump(fetch_jump), .fetch_cond(fetch_cond),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_kind(upd_kind),
        .upd_target(upd_target)
    );

    typedef struct packed {
        logic        uv;
        logic [31:0] ua;
        logic [1:0]  uk;
        logic [31:0] ut;
        logic [31:0] fa;
        logic        eh;
        logic [1:0]  ek;
        logic [31:0] et;
    } vec_t;

    // set 5 addresses: 0x214 0x414 0x614 0x814 0xA14 0xC14 (tags 1..6)
    // set 9 addresses: 0x224 0x424 0x624 0x824 0xA24
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0,     2'd0, 32'h0,    32'h214,   1'b0, 2'd0, 32'h0},    // 0  R10 empty
        '{1'b1, 32'h214,   2'd3, 32'h1000, 32'h214,   1'b1, 2'd3, 32'h1000}, // 1  R9 way0
        '{1'b0, 32'h0,     2'd0, 32'h0,    32'h20214, 1'b1, 2'd3, 32'h1000}, // 2  R3 alias
        '{1'b1, 32'h414,   2'd0, 32'h2000, 32'h214,   1'b1, 2'd3, 32'h1000}, // 3  R7 way1
        '{1'b0, 32'h0,     2'd0, 32'h0,    32'h414,   1'b1, 2'd0, 32'h2000}, // 4  R4
        '{1'b1, 32'h214,   2'd2, 32'h3000, 32'h414,   1'b1, 2'd0, 32'h2000}, // 5  R6 in place
        '{1'b0, 32'h0,     2'd0, 32'h0,    32'h214,   1'b1, 2'd2, 32'h3000}, // 6  R6
        '{1'b1, 32'h614,   2'd1, 32'h4000, 32'h614,   1'b1, 2'd1, 32'h4000}, // 7  R5 way2
        '{1'b1, 32'h814,   2'd3, 32'h5000, 32'h214,   1'b1, 2'd2, 32'h3000}, // 8  R6 way3
        '{1'b1, 32'hA14,   2'd0, 32'h6000, 32'h214,   1'b0, 2'd0, 32'h0},    // 9  R7 evict way0
        '{1'b0, 32'h0,     2'd0, 32'h0,    32'h414,   1'b1, 2'd0, 32'h2000}, // 10 R7
        '{1'b0, 32'h0,     2'd0, 32'h0,    32'hA14,   1'b1, 2'd0, 32'h6000}, // 11 R4
        '{1'b1, 32'h224,   2'd3, 32'h7000, 32'h224,   1'b1, 2'd3, 32'h7000}, // 12 R8 set9 way0
        '{1'b0, 32'h424,   2'd3, 32'h8000, 32'h424,   1'b0, 2'd0, 32'h0},    // 13 R11 ignored
        '{1'b0, 32'h0,     2'd0, 32'h0,    32'h814,   1'b1, 2'd3, 32'h5000}, // 14 R4
        '{1'b1, 32'hC14,   2'd2, 32'h9000, 32'h414,   1'b0, 2'd0, 32'h0},    // 15 R7 evict way1
        '{1'b1, 32'h424,   2'd0, 32'h8100, 32'h224,   1'b1, 2'd3, 32'h7000}, // 16 R8
        '{1'b1, 32'h624,   2'd0, 32'h8200, 32'h224,   1'b1, 2'd3, 32'h7000}, // 17 R8
        '{1'b1, 32'h824,   2'd0, 32'h8300, 32'h224,   1'b1, 2'd3, 32'h7000}, // 18 R8
        '{1'b1, 32'hA24,   2'd0, 32'h8400, 32'h224,   1'b0, 2'd0, 32'h0}     // 19 R8 evict
    };

    function automatic string vec_req(int i);
        case (i)
            0:                       return "R10";
            1:                       return "R9";
            2:                       return "R3";
            3, 9, 10, 15:            return "R7";
            5, 6, 8:                 return "R6";
            7:                       return "R5";
            12, 16, 17, 18, 19:      return "R8";
            13:                      return "R11";
            default:                 return "R4";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic uv, input logic [31:0] ua, input logic [1:0] uk,
                         input logic [31:0] ut, input logic [31:0] fa);
        upd_valid  = uv;
        upd_addr   = ua;
        upd_kind   = uk;
        upd_target = ut;
        fetch_addr = fa;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic eh, input logic [1:0] ek,
                              input logic [31:0] et);
        logic exp_jump, exp_cond;
        exp_jump = eh && ek[1];
        exp_cond = eh && (ek == 2'b00);
        check(req, "hit",    32'(fetch_hit),  32'(eh));
        check(req, "kind",   32'(fetch_kind), 32'(ek));
        check(req, "target", fetch_target,    et);
        check("R5", "jump",  32'(fetch_jump), 32'(exp_jump));
        check("R5", "cond",  32'(fetch_cond), 32'(exp_cond));
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs clear while held in reset
        expect_out("R1", 1'b0, 2'd0, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].uv, VECS[i].ua, VECS[i].uk, VECS[i].ut, VECS[i].fa);
            expect_out(vec_req(i), VECS[i].eh, VECS[i].ek, VECS[i].et);
        end

        // R2: low two bits do not matter for matching
        drive(1'b0, 32'h0, 2'd0, 32'h0, 32'h817);
        expect_out("R2", 1'b1, 2'd3, 32'h5000);
        // R2: a differing tag bit (tag 0x0C vs 0x04) misses in the same set
        drive(1'b0, 32'h0, 2'd0, 32'h0, 32'h1814);
        expect_out("R2", 1'b0, 2'd0, 32'h0);
        // R5: call kind written via 0xC14 reads back as direct
        drive(1'b0, 32'h0, 2'd0, 32'h0, 32'hC14);
        expect_out("R5", 1'b1, 2'd2, 32'h9000);
        // R11: with no write and the same address the outputs hold
        drive(1'b0, 32'h0, 2'd0, 32'h0, 32'hC14);
        expect_out("R11", 1'b1, 2'd2, 32'h9000);

        // R1: mid-run reset empties the table
        rst = 1'b1;
        drive(1'b0, 32'h0, 2'd0, 32'h0, 32'h814);
        expect_out("R1", 1'b0, 2'd0, 32'h0);
        rst = 1'b0;
        drive(1'b0, 32'h0, 2'd0, 32'h0, 32'h814);
        expect_out("R1", 1'b0, 2'd0, 32'h0);
        // R7: pointer back at way 0 after reset; refill works
        drive(1'b1, 32'hA14, 2'd1, 32'hBEE0, 32'hA14);
        expect_out("R7", 1'b1, 2'd1, 32'hBEE0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            nchecks++;
            nerr++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    end

endmodule